// File: doc/BRIEF.md
# I2C Bus Condition Detector

This block watches the two wires of an I2C bus from inside a synchronous system and tells the rest of the controller when a start, repeated start or stop condition has occurred. Both wires are first brought into the system clock domain through a two-flop synchroniser. A condition is then accepted only if the clock line stays high long enough around the data edge. Three parameters, counted in system clock cycles, set the minimum data setup before the edge, the minimum data hold after it, and the minimum clock-high time. A data edge that misses any of these minimums is discarded.

Two flags are kept. The bus-busy flag rises on a start and falls on a stop; falling busy is the only way a stop is reported to software. The start-detected flag rises on every start or repeated start. How it clears depends on the address the byte logic receives after the start. On a mismatch, hardware clears it. On a match, it stays set until software writes the transmit buffer. One-cycle event pulses accompany each accepted start and stop.

Top module: `i2c_cond_detect`

## Requirements
- R1: A high-to-low SDA edge is a start when the synchronised SCL is high for at least SETUP_CYC (default 2) sampled cycles before the edge. SDA must then stay low with SCL high for at least HOLD_CYC (default 2) samples, counting the edge sample, and SCL must stay high for at least HIGH_CYC (default 3) samples in total. startEvt then pulses high for exactly one cycle.
- R2: An SDA edge with SCL high for fewer than SETUP_CYC samples before it produces no start or stop pulse and leaves busBusy unchanged.
- R3: An SDA edge followed by fewer than HOLD_CYC samples with SCL high and SDA at the new level produces no pulse and leaves busBusy unchanged.
- R4: A low-to-high SDA edge meeting the same setup, hold and high minimums is a stop. stopEvt pulses for exactly one cycle.
- R5: busBusy (1 = busy) rises with an accepted start and falls with an accepted stop. A repeated start while busy leaves it at 1 and still pulses startEvt.
- R6: startFlag (1 = start seen) is set by every accepted start, including a repeated start after the flag was cleared.
- R7: An addrStrobe with addrMatch = 0 while startFlag is 1 clears startFlag on the next clock edge.
- R8: After an addrStrobe with addrMatch = 1, startFlag stays at 1 until a txWrite pulse clears it. A txWrite before any matching address strobe since the last start is ignored.
- R9: A synchronous active-low reset clears busBusy, startFlag, both pulses and all duration counters.
- R10: SDA changes while SCL is low never produce a start or stop pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| sdaIn | input | 1 | Raw SDA level from the pad |
| sclIn | input | 1 | Raw SCL level from the pad |
| addrStrobe | input | 1 | One-cycle strobe: a slave address byte has been received |
| addrMatch | input | 1 | With addrStrobe: 1 if the address equals the own address |
| txWrite | input | 1 | One-cycle strobe: software wrote the transmit buffer |
| busBusy | output | 1 | Bus is busy between an accepted start and stop |
| startFlag | output | 1 | Start or repeated start detected and not yet cleared |
| startEvt | output | 1 | One-cycle pulse on an accepted start |
| stopEvt | output | 1 | One-cycle pulse on an accepted stop |

## Verification
Start and stop attempts are swept over setup lengths of one to five cycles and hold lengths of one to five cycles. This separates the exact thresholds at which an edge is accepted from those at which it is discarded, for both edge directions. A repeated start while busy shows that busy stays set and the start pulse repeats. SDA toggling under a low SCL shows that data traffic never fakes a condition. Directed address sequences cover the mismatch auto-clear, a premature transmit-buffer write, the match-then-write clear, and a reset taken in the middle of a transaction.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;
  // qualifiers from the datapath to the control
  typedef struct packed {
    logic sdaNow;
    logic sclNow;
    logic sdaEdge;
    logic setupOk;
    logic holdOk;
    logic highOk;
  } qualT;

  // strobes from the control to the datapath
  typedef struct packed {
    logic markStart;
    logic markStop;
  } strobeT;

  typedef enum logic [1:0] {
    WATCH      = 2'd0,
    HOLD_START = 2'd1,
    HOLD_STOP  = 2'd2
  } phaseT;
endpackage

// File: rtl/i2c_cond_dp.sv
module i2c_cond_dp
  import i2c_cond_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 2,
  parameter int HIGH_CYC  = 3
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sdaIn,
  input  logic   sclIn,
  input  logic   addrStrobe,
  input  logic   addrMatch,
  input  logic   txWrite,
  input  strobeT strb,
  output qualT   qual,
  output logic   busBusy,
  output logic   startFlag,
  output logic   startEvt,
  output logic   stopEvt
);
  localparam int MAX_REQ = (SETUP_CYC > HOLD_CYC) ?
                           ((SETUP_CYC > HIGH_CYC) ? SETUP_CYC : HIGH_CYC) :
                           ((HOLD_CYC > HIGH_CYC) ? HOLD_CYC : HIGH_CYC);
  localparam int CNT_W = $clog2(MAX_REQ + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int LINES = 2;  // bit 0 = SDA, bit 1 = SCL

  logic [LINES-1:0] rawIn, syncA, syncB;
  logic             sdaD;
  logic [CNT_W-1:0] sdaCnt, sclCnt;
  logic             matchSeen;

  assign rawIn = {sclIn, sdaIn};

  // two-flop synchroniser, one chain per bus line
  for (genvar g = 0; g < LINES; g++) begin : gSync
    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncA[g] <= 1'b1;
        syncB[g] <= 1'b1;
      end else begin
        syncA[g] <= rawIn[g];
        syncB[g] <= syncA[g];
      end
    end
  end

  // sdaCnt: consecutive samples of the previous SDA level
  // sclCnt: consecutive high SCL samples up to the previous cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdaD   <= 1'b1;
      sdaCnt <= '0;
      sclCnt <= '0;
    end else begin
      sdaD <= syncB[0];
      if (syncB[0] != sdaD)    sdaCnt <= CNT_W'(1);
      else if (sdaCnt != CNT_MAX) sdaCnt <= sdaCnt + 1'b1;
      if (!syncB[1])           sclCnt <= '0;
      else if (sclCnt != CNT_MAX) sclCnt <= sclCnt + 1'b1;
    end
  end

  always_comb begin
    qual.sdaNow  = syncB[0];
    qual.sclNow  = syncB[1];
    qual.sdaEdge = (syncB[0] != sdaD);
    qual.setupOk = (sdaCnt >= CNT_W'(SETUP_CYC)) && (sclCnt >= CNT_W'(SETUP_CYC));
    qual.holdOk  = (sdaCnt >= CNT_W'(HOLD_CYC - 1));
    qual.highOk  = (sclCnt >= CNT_W'(HIGH_CYC - 1));
  end

  // flags and event pulses
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busBusy   <= 1'b0;
      startFlag <= 1'b0;
      matchSeen <= 1'b0;
      startEvt  <= 1'b0;
      stopEvt   <= 1'b0;
    end else begin
      startEvt <= strb.markStart;
      stopEvt  <= strb.markStop;
      if (strb.markStart)     busBusy <= 1'b1;
      else if (strb.markStop) busBusy <= 1'b0;
      if (strb.markStart) begin
        startFlag <= 1'b1;
        matchSeen <= 1'b0;
      end else if (startFlag && addrStrobe) begin
        if (addrMatch) matchSeen <= 1'b1;
        else           startFlag <= 1'b0;
      end else if (startFlag && matchSeen && txWrite) begin
        startFlag <= 1'b0;
        matchSeen <= 1'b0;
      end
    end
  end

  assert_busy_on_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    startEvt |-> busBusy);
  assert_busy_off_stop_R5: assert property (@(posedge clk) disable iff (!rstN)
    stopEvt |-> !busBusy);
  assert_busy_falls_on_stop_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busBusy) |-> stopEvt);
  assert_flag_on_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    startEvt |-> startFlag);
  assert_mismatch_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (startFlag && addrStrobe && !addrMatch && !strb.markStart) |=> !startFlag);
  assert_evt_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(startEvt && stopEvt));
endmodule

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl
  import i2c_cond_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  qualT   qual,
  output strobeT strb
);
  phaseT phase, phaseNext;

  always_comb begin
    phaseNext = phase;
    strb      = '0;
    unique case (phase)
      WATCH: begin
        if (qual.sdaEdge && qual.sclNow && qual.setupOk)
          phaseNext = qual.sdaNow ? HOLD_STOP : HOLD_START;
      end
      HOLD_START, HOLD_STOP: begin
        if (!qual.sclNow || qual.sdaEdge) begin
          phaseNext = WATCH;
        end else if (qual.holdOk && qual.highOk) begin
          phaseNext      = WATCH;
          strb.markStart = (phase == HOLD_START);
          strb.markStop  = (phase == HOLD_STOP);
        end
      end
      default: phaseNext = WATCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= WATCH;
    else       phase <= phaseNext;
  end

  assert_start_under_scl_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.markStart |-> (qual.sclNow && !qual.sdaNow));
  assert_stop_under_scl_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.markStop |-> (qual.sclNow && qual.sdaNow));
  assert_setup_gate_R2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == WATCH && qual.sdaEdge && !qual.setupOk) |=> phase == WATCH);
  assert_scl_low_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !qual.sclNow |-> !(strb.markStart || strb.markStop));
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
  import i2c_cond_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 2,
  parameter int HIGH_CYC  = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic sdaIn,
  input  logic sclIn,
  input  logic addrStrobe,
  input  logic addrMatch,
  input  logic txWrite,
  output logic busBusy,
  output logic startFlag,
  output logic startEvt,
  output logic stopEvt
);
  qualT   qual;
  strobeT strb;

  i2c_cond_dp #(
    .SETUP_CYC(SETUP_CYC),
    .HOLD_CYC (HOLD_CYC),
    .HIGH_CYC (HIGH_CYC)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .sdaIn     (sdaIn),
    .sclIn     (sclIn),
    .addrStrobe(addrStrobe),
    .addrMatch (addrMatch),
    .txWrite   (txWrite),
    .strb      (strb),
    .qual      (qual),
    .busBusy   (busBusy),
    .startFlag (startFlag),
    .startEvt  (startEvt),
    .stopEvt   (stopEvt)
  );

  i2c_cond_ctrl uCtrl (
    .clk (clk),
    .rstN(rstN),
    .qual(qual),
    .strb(strb)
  );
endmodule

// File: tb/tb_i2c_cond_detect.sv
module tb_i2c_cond_detect;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sdaIn = 1'b1, sclIn = 1'b1;
  logic addrStrobe = 1'b0, addrMatch = 1'b0, txWrite = 1'b0;
  logic busBusy, startFlag, startEvt, stopEvt;

  int checks = 0, fails = 0;
  int startCnt = 0, stopCnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;  // 100 MHz

  i2c_cond_detect dut (
    .clk(clk), .rstN(rstN), .sdaIn(sdaIn), .sclIn(sclIn),
    .addrStrobe(addrStrobe), .addrMatch(addrMatch), .txWrite(txWrite),
    .busBusy(busBusy), .startFlag(startFlag), .startEvt(startEvt), .stopEvt(stopEvt)
  );

  // counts high cycles of each pulse
  always @(negedge clk) begin
    if (startEvt) startCnt++;
    if (stopEvt)  stopCnt++;
  end

  // vector: {isStop, setupCyc[4], holdCyc[4], expStart[2], expStop[2], expBusy, req[3]}
  localparam logic [16:0] VECS [0:8] = '{
    {1'b0, 4'd3, 4'd3, 2'd1, 2'd0, 1'b1, 3'd1},  // R1 plain start
    {1'b0, 4'd2, 4'd2, 2'd1, 2'd0, 1'b1, 3'd5},  // R5 repeated start at minimums
    {1'b1, 4'd2, 4'd2, 2'd0, 2'd1, 1'b0, 3'd4},  // R4 stop at minimums
    {1'b0, 4'd1, 4'd4, 2'd0, 2'd0, 1'b0, 3'd2},  // R2 start setup too short
    {1'b0, 4'd4, 4'd1, 2'd0, 2'd0, 1'b0, 3'd3},  // R3 start hold too short
    {1'b0, 4'd2, 4'd5, 2'd1, 2'd0, 1'b1, 3'd1},  // R1 start long hold
    {1'b1, 4'd1, 4'd3, 2'd0, 2'd0, 1'b1, 3'd2},  // R2 stop setup too short
    {1'b1, 4'd3, 4'd1, 2'd0, 2'd0, 1'b1, 3'd3},  // R3 stop hold too short
    {1'b1, 4'd5, 4'd5, 2'd0, 2'd1, 1'b0, 3'd4}   // R4 stop long setup
  };

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic runCond(input logic isStop, input int setupCyc, input int holdCyc);
    @(negedge clk) sclIn = 1'b0;
    repeat (3) @(negedge clk);
    sdaIn = isStop ? 1'b0 : 1'b1;
    repeat (4) @(negedge clk);
    startCnt = 0;
    stopCnt  = 0;
    sclIn = 1'b1;
    repeat (setupCyc) @(negedge clk);
    sdaIn = isStop ? 1'b1 : 1'b0;
    repeat (holdCyc) @(negedge clk);
    sclIn = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse(input int which, input logic match);
    @(negedge clk);
    addrMatch = match;
    if (which == 0) addrStrobe = 1'b1; else txWrite = 1'b1;
    @(negedge clk);
    addrStrobe = 1'b0;
    txWrite    = 1'b0;
  endtask

  initial begin
    // R9 reset state
    repeat (4) @(negedge clk);
    check(int'(busBusy), 0, "R9 busy after reset");
    check(int'(startFlag), 0, "R9 flag after reset");
    check(int'(startEvt | stopEvt), 0, "R9 pulses after reset");
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    foreach (VECS[i]) begin
      logic [16:0] v;
      string tag;
      v = VECS[i];
      runCond(v[16], int'(v[15:12]), int'(v[11:8]));
      tag = $sformatf("R%0d vector %0d", v[2:0], i);
      check(startCnt, int'(v[7:6]), {tag, " start pulses"});
      check(stopCnt, int'(v[5:4]), {tag, " stop pulses"});
      check(int'(busBusy), int'(v[3]), {tag, " busy"});
    end

    // R10: SDA toggling with SCL low
    startCnt = 0;
    stopCnt  = 0;
    for (int k = 0; k < 6; k++) begin
      sdaIn = ~sdaIn;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    check(startCnt + stopCnt, 0, "R10 no pulses with SCL low");
    check(int'(busBusy), 0, "R10 busy unchanged");

    // R7 mismatch clears the flag left by earlier starts
    check(int'(startFlag), 1, "R6 flag held from earlier start");
    pulse(0, 1'b0);
    check(int'(startFlag), 0, "R7 mismatch clears flag");

    // R6 / R8 flag set, premature write, match then write
    runCond(1'b0, 3, 3);
    check(int'(startFlag), 1, "R6 flag set by start");
    check(int'(busBusy), 1, "R5 busy set by start");
    pulse(1, 1'b0);
    check(int'(startFlag), 1, "R8 write before match ignored");
    pulse(0, 1'b1);
    check(int'(startFlag), 1, "R8 flag held after match");
    pulse(1, 1'b0);
    check(int'(startFlag), 0, "R8 write after match clears flag");

    // R5 / R6 repeated start re-sets the flag
    runCond(1'b0, 2, 3);
    check(startCnt, 1, "R5 repeated start pulse");
    check(int'(busBusy), 1, "R5 busy stays set");
    check(int'(startFlag), 1, "R6 flag set by repeated start");

    // R9 reset during a transaction
    @(negedge clk) rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(int'(busBusy), 0, "R9 busy cleared by reset");
    check(int'(startFlag), 0, "R9 flag cleared by reset");
    rstN = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule